// File: doc/BRIEF.md
# Latched Line-Status Event Bank

This block gathers six live condition signals from each line port of a multi-port line interface. It turns transitions and error pulses on them into sticky event bits that software can read and acknowledge, and folds the enabled events into one interrupt line. Each port owns two host-visible registers. One holds the sticky event bits and is cleared by writing ones. The other holds the interrupt enables for those bits.

The triggers are not uniform across the bits of a port. Loss-of-signal, loss-of-lock, pattern-sync and driver-monitor conditions set their bit on any change of level. Code-violation sets its bit only when the condition rises. The pattern bit-error bit sets only while an error pulse is present and the pattern detector reports sync. The live inputs first pass through a synchronizer chain. The block keeps a registered copy of each synchronized value to find edges. That copy, like the synchronizer, is loaded from the inputs while reset is held, so leaving reset does not create an event. The host interface has an address, a write strobe, write data and registered read data that always follow the address.

Top module: `lsi_bank`

## Requirements
- R1: While reset is held (synchronous, active low, clock running), every sticky bit and every enable becomes zero and the interrupt goes low. Inputs that are steady and non-zero across reset release create no event.
- R2: Bits 0 (loss of signal), 1 (loss of clock lock), 4 (pattern sync) and 5 (driver monitor) of a port set when the matching input changes level, in either direction. The input of port n, bit b sits at st_live[6n+b].
- R3: Bit 2 (code violation) sets on a rising input only. A falling input leaves it clear.
- R4: Bit 3 (pattern bit error) sets in each cycle in which its synchronized error input is high while the synchronized bit-4 sync input of the same port is high. An error with sync low sets nothing.
- R5: A write to the sticky register of port n at address 0x04 + 0x10·n clears each bit written as one. Bits written as zero keep their value.
- R6: A sticky bit rises only in the cycle after a qualifying event, so once cleared it stays clear until a new event.
- R7: When a qualifying event and a clearing write for the same bit occur in the same cycle, the bit ends up set.
- R8: irq is a register holding the OR, over all ports and bits, of sticky AND enable. It is high one cycle after any such pair is one, and low one cycle after clearing either the sticky bit or its enable removes the last pair.
- R9: The enables of port n sit at 0x05 + 0x10·n, in the same bit positions as the sticky bits. Read data bits 7 and 6 are always zero. Every other address reads zero and ignores writes, and an access to one port's registers leaves the other ports unchanged.
- R10: With the default two-stage synchronizer, an input change sampled at clock edge k sets the sticky bit at edge k+2. It appears on reg_rdata and irq at edge k+3. reg_rdata always shows the register at the address sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_live | input | NUM_PORTS*6 | Live condition inputs, six per port |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Active-high interrupt |

## Verification
Some rules are checked on every cycle. A sticky bit never falls unless a clearing write hit it. It never rises without an event from the detectors, and an event always leaves its bit set, even when a clear arrives in the same cycle. The interrupt always matches the previous cycle's masked sticky state, and the unused read-data bits stay zero. The bench's scenarios cover the rest. They show which input shapes count as events for each bit kind: falling code violation, an error without sync, and toggles in both directions. They also cover the address map and its isolation between ports, the exact latency from input to read data and interrupt, and the reset behaviour with live inputs non-zero.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

   localparam int LSI_BITS     = 6;
   localparam int LSI_QUAL_SRC = 4;

   typedef enum logic [1:0] {
      TRIG_TOGGLE    = 2'd0,
      TRIG_RISE      = 2'd1,
      TRIG_QUALIFIED = 2'd2
   } trig_e;

   // trigger kind of each event bit within a port
   function automatic trig_e trig_of(input int b);
      case (b)
         2:       return TRIG_RISE;
         3:       return TRIG_QUALIFIED;
         default: return TRIG_TOGGLE;
      endcase
   endfunction

endpackage

// File: rtl/lsi_sync.sv
module lsi_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   // while reset is held every stage follows the input directly
   always_ff @(posedge clk) begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
         stg[i] <= rst_n ? stg[i-1] : d;
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/lsi_evt.sv
module lsi_evt
   import lsi_pkg::*;
#(
   parameter int NB = LSI_BITS
) (
   input  logic          clk,
   input  logic [NB-1:0] lvl,
   output logic [NB-1:0] evt
);

   for (genvar b = 0; b < NB; b++) begin : g_bit
      if (trig_of(b) == TRIG_QUALIFIED) begin : g_qual
         assign evt[b] = lvl[b] & lvl[LSI_QUAL_SRC];
      end else begin : g_edge
         logic prev;
         always_ff @(posedge clk) prev <= lvl[b];
         if (trig_of(b) == TRIG_RISE) begin : g_rise
            assign evt[b] = lvl[b] & ~prev;
         end else begin : g_tog
            assign evt[b] = lvl[b] ^ prev;
         end
      end
   end

endmodule

// File: rtl/lsi_port.sv
module lsi_port #(
   parameter int NB = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] evt,
   input  logic [NB-1:0] clr,
   input  logic          en_we,
   input  logic [NB-1:0] wbits,
   output logic [NB-1:0] lat,
   output logic [NB-1:0] en
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat <= '0;
         en  <= '0;
      end else begin
         // a new event outranks a clear landing in the same cycle
         lat <= (lat & ~clr) | evt;
         if (en_we) en <= wbits;
      end
   end

endmodule

// File: rtl/lsi_bank.sv
module lsi_bank
   import lsi_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PORT_STRIDE = 16,
   parameter int LATCH_OFS   = 4,
   parameter int ENABLE_OFS  = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS*LSI_BITS-1:0] st_live,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic                          reg_we,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   output logic                          irq
);

   localparam int NB     = LSI_BITS;
   localparam int STAT_W = NUM_PORTS * NB;

   if (NUM_PORTS < 1 || NUM_PORTS * PORT_STRIDE > (1 << ADDR_W)) begin : g_bad_ports
      $error("lsi_bank: port count does not fit the address space");
   end
   if (DATA_W <= NB) begin : g_bad_data
      $error("lsi_bank: data width must exceed the event bit count");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lsi_bank: at least two synchronizer stages required");
   end
   if (LATCH_OFS == ENABLE_OFS || LATCH_OFS >= PORT_STRIDE || ENABLE_OFS >= PORT_STRIDE) begin : g_bad_ofs
      $error("lsi_bank: register offsets overlap or leave the port window");
   end

   logic [STAT_W-1:0]    lvl_all;
   logic [STAT_W-1:0]    evt_all;
   logic [STAT_W-1:0]    clr_all;
   logic [STAT_W-1:0]    lat_all;
   logic [STAT_W-1:0]    en_all;
   logic [NUM_PORTS-1:0] en_we_v;
   logic [NB-1:0]        wbits;
   logic [DATA_W-1:0]    rd_next;
   logic                 unused_wdata_hi;

   assign wbits           = reg_wdata[NB-1:0];
   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NB];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [ADDR_W-1:0] A_LAT = ADDR_W'(p * PORT_STRIDE + LATCH_OFS);
      localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(p * PORT_STRIDE + ENABLE_OFS);

      lsi_sync #(.W(NB), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (st_live[p*NB +: NB]),
         .q     (lvl_all[p*NB +: NB])
      );

      lsi_evt #(.NB(NB)) u_evt (
         .clk (clk),
         .lvl (lvl_all[p*NB +: NB]),
         .evt (evt_all[p*NB +: NB])
      );

      assign clr_all[p*NB +: NB] = (reg_we && reg_addr == A_LAT) ? wbits : '0;
      assign en_we_v[p]          = reg_we && reg_addr == A_EN;

      lsi_port #(.NB(NB)) u_port (
         .clk   (clk),
         .rst_n (rst_n),
         .evt   (evt_all[p*NB +: NB]),
         .clr   (clr_all[p*NB +: NB]),
         .en_we (en_we_v[p]),
         .wbits (wbits),
         .lat   (lat_all[p*NB +: NB]),
         .en    (en_all[p*NB +: NB])
      );
   end

   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (reg_addr == ADDR_W'(p * PORT_STRIDE + LATCH_OFS)) rd_next = DATA_W'(lat_all[p*NB +: NB]);
         if (reg_addr == ADDR_W'(p * PORT_STRIDE + ENABLE_OFS)) rd_next = DATA_W'(en_all[p*NB +: NB]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         irq       <= 1'b0;
      end else begin
         reg_rdata <= rd_next;
         irq       <= |(lat_all & en_all);
      end
   end

endmodule

// File: rtl/lsi_bank_chk.sv
module lsi_bank_chk #(
   parameter int STAT_W = 24,
   parameter int NB     = 6,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] lat_all,
   input logic [STAT_W-1:0] en_all,
   input logic [STAT_W-1:0] evt_all,
   input logic [STAT_W-1:0] clr_all,
   input logic              irq,
   input logic [DATA_W-1:0] reg_rdata
);

   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(lat_all & en_all)));

   p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|(lat_all & en_all)) |-> irq);

   p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt_all) & ~lat_all) == '0));

   p_fall_by_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(lat_all) & ~lat_all & ~$past(clr_all)) == '0));

   p_rise_by_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((~$past(lat_all) & lat_all & ~$past(evt_all)) == '0));

   p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[DATA_W-1:NB] == '0));

endmodule

bind lsi_bank lsi_bank_chk #(.STAT_W(STAT_W), .NB(NB), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lat_all   (lat_all),
   .en_all    (en_all),
   .evt_all   (evt_all),
   .clr_all   (clr_all),
   .irq       (irq),
   .reg_rdata (reg_rdata)
);

// File: tb/sim_lsi_bank.sv
`timescale 1ns/1ps
module sim_lsi_bank;

   localparam int SW = 24;
   localparam logic [1:0] K_DRV = 2'd0;
   localparam logic [1:0] K_WR  = 2'd1;
   localparam logic [1:0] K_RD  = 2'd2;
   localparam logic [1:0] K_IRQ = 2'd3;
   localparam int NV = 53;

   // {kind, req, addr, data, live, expected}
   localparam logic [53:0] VEC [NV] = '{
      {K_RD,  4'd1,  8'h04, 8'h00, 24'h0,      8'h00},  // R1
      {K_RD,  4'd1,  8'h15, 8'h00, 24'h0,      8'h00},  // R1
      {K_RD,  4'd1,  8'h34, 8'h00, 24'h0,      8'h00},  // R1
      {K_IRQ, 4'd1,  8'h00, 8'h00, 24'h0,      8'h00},  // R1
      {K_WR,  4'd9,  8'h05, 8'h3F, 24'h0,      8'h00},
      {K_RD,  4'd9,  8'h05, 8'h00, 24'h0,      8'h3F},  // R9
      {K_DRV, 4'd2,  8'h00, 8'h00, 24'hDF7DF6, 8'h00},  // p0 los falls
      {K_RD,  4'd2,  8'h04, 8'h00, 24'h0,      8'h01},  // R2
      {K_IRQ, 4'd8,  8'h00, 8'h00, 24'h0,      8'h01},  // R8
      {K_WR,  4'd5,  8'h04, 8'h00, 24'h0,      8'h00},
      {K_RD,  4'd5,  8'h04, 8'h00, 24'h0,      8'h01},  // R5 zero keeps
      {K_WR,  4'd5,  8'h04, 8'h01, 24'h0,      8'h00},
      {K_RD,  4'd5,  8'h04, 8'h00, 24'h0,      8'h00},  // R5 one clears
      {K_IRQ, 4'd8,  8'h00, 8'h00, 24'h0,      8'h00},  // R8
      {K_DRV, 4'd3,  8'h00, 8'h00, 24'hDF7DF2, 8'h00},  // cv falls
      {K_RD,  4'd3,  8'h04, 8'h00, 24'h0,      8'h00},  // R3
      {K_DRV, 4'd3,  8'h00, 8'h00, 24'hDF7DF6, 8'h00},  // cv rises
      {K_RD,  4'd3,  8'h04, 8'h00, 24'h0,      8'h04},  // R3
      {K_WR,  4'd5,  8'h04, 8'h04, 24'h0,      8'h00},
      {K_DRV, 4'd2,  8'h00, 8'h00, 24'hDF7DE6, 8'h00},  // sync falls
      {K_RD,  4'd2,  8'h04, 8'h00, 24'h0,      8'h10},  // R2
      {K_DRV, 4'd4,  8'h00, 8'h00, 24'hDF7DEE, 8'h00},  // error, no sync
      {K_RD,  4'd4,  8'h04, 8'h00, 24'h0,      8'h10},  // R4
      {K_DRV, 4'd4,  8'h00, 8'h00, 24'hDF7DE6, 8'h00},
      {K_WR,  4'd5,  8'h04, 8'h10, 24'h0,      8'h00},
      {K_DRV, 4'd2,  8'h00, 8'h00, 24'hDF7DF6, 8'h00},  // sync rises
      {K_RD,  4'd2,  8'h04, 8'h00, 24'h0,      8'h10},  // R2
      {K_WR,  4'd5,  8'h04, 8'h10, 24'h0,      8'h00},
      {K_DRV, 4'd4,  8'h00, 8'h00, 24'hDF7DFE, 8'h00},  // error in sync
      {K_RD,  4'd4,  8'h04, 8'h00, 24'h0,      8'h08},  // R4
      {K_DRV, 4'd4,  8'h00, 8'h00, 24'hDF7DF6, 8'h00},
      {K_WR,  4'd5,  8'h04, 8'h08, 24'h0,      8'h00},
      {K_RD,  4'd6,  8'h04, 8'h00, 24'h0,      8'h00},  // R6
      {K_DRV, 4'd9,  8'h00, 8'h00, 24'hDF5DF6, 8'h00},  // p2 lol falls
      {K_RD,  4'd9,  8'h24, 8'h00, 24'h0,      8'h02},  // R9
      {K_RD,  4'd6,  8'h04, 8'h00, 24'h0,      8'h00},  // R6
      {K_IRQ, 4'd8,  8'h00, 8'h00, 24'h0,      8'h00},  // R8 masked
      {K_WR,  4'd8,  8'h25, 8'h02, 24'h0,      8'h00},
      {K_IRQ, 4'd8,  8'h00, 8'h00, 24'h0,      8'h01},  // R8
      {K_WR,  4'd8,  8'h25, 8'h00, 24'h0,      8'h00},
      {K_IRQ, 4'd8,  8'h00, 8'h00, 24'h0,      8'h00},  // R8 enable off
      {K_RD,  4'd8,  8'h24, 8'h00, 24'h0,      8'h02},  // R8 sticky kept
      {K_WR,  4'd5,  8'h24, 8'hFF, 24'h0,      8'h00},
      {K_RD,  4'd5,  8'h24, 8'h00, 24'h0,      8'h00},  // R5
      {K_WR,  4'd9,  8'h06, 8'hFF, 24'h0,      8'h00},
      {K_RD,  4'd9,  8'h06, 8'h00, 24'h0,      8'h00},  // R9
      {K_RD,  4'd9,  8'h05, 8'h00, 24'h0,      8'h3F},  // R9
      {K_DRV, 4'd2,  8'h00, 8'h00, 24'h5F5DF6, 8'h00},  // p3 drv falls
      {K_RD,  4'd2,  8'h34, 8'h00, 24'h0,      8'h20},  // R2
      {K_WR,  4'd5,  8'h34, 8'h20, 24'h0,      8'h00},
      {K_RD,  4'd5,  8'h34, 8'h00, 24'h0,      8'h00},  // R5
      {K_WR,  4'd9,  8'h05, 8'hFF, 24'h0,      8'h00},
      {K_RD,  4'd9,  8'h05, 8'h00, 24'h0,      8'h3F}   // R9 pad bits
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] st_live;
   logic [7:0]    reg_addr;
   logic          reg_we;
   logic [7:0]    reg_wdata;
   logic [7:0]    reg_rdata;
   logic          irq;
   int            n_vec = 0;
   int            n_bad = 0;
   logic [53:0]   v;

   always #10 clk = ~clk;

   lsi_bank u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_live   (st_live),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      finish_run();
   end

   initial begin
      st_live = 24'hDF7DF7;
      reg_addr = 8'h00; reg_wdata = 8'h00; reg_we = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         case (v[53:52])
            K_DRV: begin
               @(negedge clk);
               st_live = v[31:8];
               repeat (5) @(posedge clk);
            end
            K_WR: do_wr(v[47:40], v[39:32]);
            K_RD: begin
               do_rd(v[47:40]);
               chk($sformatf("R%0d vector %0d", v[51:48], i), reg_rdata, v[7:0]);
            end
            default: begin
               repeat (2) @(posedge clk);
               @(negedge clk);
               chk($sformatf("R%0d vector %0d irq", v[51:48], i), {7'b0, irq}, v[7:0]);
            end
         endcase
      end

      // R10: latency from input change to sticky read-back and interrupt
      @(negedge clk);
      reg_addr = 8'h04;
      st_live  = 24'h5F5DF4;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 rdata before", reg_rdata, 8'h00);
      chk("R10 irq before", {7'b0, irq}, 8'h00);
      @(posedge clk);
      @(negedge clk);
      chk("R10 rdata at k+3", reg_rdata, 8'h02);
      chk("R10 irq at k+3", {7'b0, irq}, 8'h01);

      // R7: clear and new event on the same bit in the same cycle
      @(negedge clk);
      st_live = 24'h5F5DF6;
      repeat (2) @(posedge clk);
      @(negedge clk);
      reg_addr = 8'h04; reg_wdata = 8'h02; reg_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R7 event beats clear", reg_rdata, 8'h02);
      do_wr(8'h04, 8'h02);
      do_rd(8'h04);
      chk("R5 clear after R7", reg_rdata, 8'h00);

      // R1: reset with live inputs non-zero and changing inside reset
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      st_live = 24'h5F5DB6;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(posedge clk);
      do_rd(8'h14);
      chk("R1 port1 sticky after reset", reg_rdata, 8'h00);
      do_rd(8'h05);
      chk("R1 enable after reset", reg_rdata, 8'h00);
      chk("R1 irq after reset", {7'b0, irq}, 8'h00);

      finish_run();
   end

endmodule